// File: doc/BRIEF.md
# Serial Receiver Status and Data Holding Register

This block sits between the front end of a serial receiver and a simple CPU read bus. When the front end signals that a character has completed, the block moves the character into a holding register and raises a data-available flag. It also keeps three more flags. The idle flag reports a quiet receive line. The overrun flag reports that a character was lost because the previous one had not yet been collected. The noise flag reports a noisy character.

Software collects a character in two steps. It first reads the status word and then reads the data register. That pair of reads is the only way to clear a flag. On each status read, the block records which flags were visible. The data read that follows clears only those recorded flags, so a flag that appears between the two reads is not lost.

Three interrupt requests are formed from the flags and their enable inputs. The idle request is also suppressed while DMA receive is selected. Baud generation, bit sampling, start-bit search and the transmitter belong to other blocks.

Top module: `rx_status_ctrl`

## Requirements
- R1: A character-complete pulse (`char_done` high while `rx_en` is high) that arrives while the data-available flag is clear loads `char_data` into the data register and sets the data-available flag (status bit 5, mask 0x20). A status read is `bus_rd` high with `bus_addr` = 0; a data read is `bus_rd` high with `bus_addr` = 1. Read data is combinational on `rd_data`.
- R2: The data-available flag clears only on a data read that follows a status read that saw the flag set. A data read without such a status read leaves the flag set.
- R3: A character that completes while the data-available flag is set sets the overrun flag (status bit 3, mask 0x08). That character is discarded and the data register keeps its old contents.
- R4: A data read clears the overrun flag only if the flag was set at the preceding status read. An overrun that arises between the status read and the data read survives the data read.
- R5: A completed character reported with `char_noise` high sets the noise flag (status bit 2, mask 0x04). The flag clears through the same status-then-data read sequence.
- R6: The idle flag (status bit 4, mask 0x10) sets once the receive line has been 1 on consecutive `sample_tick` strobes: 10 strobes with `nine_bit` = 0, or 11 strobes with `nine_bit` = 1. A strobe that samples 0 restarts the count.
- R7: After `rx_en` rises, and again after each clearing of the idle flag, the idle flag cannot set until a character has been accepted into the data register.
- R8: `irq_idle` is the idle flag gated by `ie_idle` and by `dma_rx_en` being low. `irq_ovr` is the overrun flag gated by `ie_ovr`. `irq_noise` is the noise flag gated by `ie_noise`.
- R9: Reset clears all four flags and the data register. All other status bits always read 0.
- R10: When a flag-setting event and a clearing data read fall in the same clock cycle, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| char_done | input | 1 | One-cycle pulse: a character has completed |
| char_data | input | DATA_W | Completed character |
| char_noise | input | 1 | Noise seen on the completed character |
| sample_tick | input | 1 | One strobe per bit time |
| line_sample | input | 1 | Receive line value at the strobe |
| nine_bit | input | 1 | 1 selects 9-bit characters (11-bit idle threshold) |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 1 | 0 selects the status word, 1 selects the data register |
| rd_data | output | BUS_W | Read data |
| ie_idle | input | 1 | Idle interrupt enable |
| dma_rx_en | input | 1 | DMA receive selected; masks the idle interrupt |
| ie_ovr | input | 1 | Overrun interrupt enable |
| ie_noise | input | 1 | Noise interrupt enable |
| irq_idle | output | 1 | Idle interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |
| irq_noise | output | 1 | Noise interrupt request |

## Verification
The clearing sequence is tried in several orders. A proper status-then-data pair must clear the flags it saw. A lone data read must clear nothing. An overrun placed between the two reads must survive the data read and leave the held character in place, which separates the recorded-flag rule from a plain clear on every data read. Idle runs of nine, ten and eleven ones, with and without a 0 strobe in the middle, separate the two thresholds and the restart. Idle runs taken before any character, and again right after an idle clear, show that a new character is needed first. A data read placed in the same cycle as a noisy overrun shows that the set wins.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
   localparam int NUM_FLAGS = 4;
   typedef enum int {FL_AVAIL = 0, FL_IDLE = 1, FL_OVR = 2, FL_NOISE = 3} flag_idx_e;
   // status word bit positions
   localparam int ST_AVAIL = 5;
   localparam int ST_IDLE  = 4;
   localparam int ST_OVR   = 3;
   localparam int ST_NOISE = 2;
   localparam int ST_TOP   = 5;
endpackage

// File: rtl/rx_flag_cell.sv
module rx_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic st_rd,
   input  logic dt_rd,
   output logic flag_o,
   output logic cleared_o
);
   logic flag_q, armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (st_rd)      armed_q <= flag_q;
         else if (dt_rd) armed_q <= 1'b0;
         if (set_ev)                flag_q <= 1'b1;
         else if (dt_rd && armed_q) flag_q <= 1'b0;
      end
   end

   assign flag_o    = flag_q;
   assign cleared_o = dt_rd && armed_q && !set_ev;

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag_q);
   assert_clear_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(dt_rd && armed_q));
endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
   parameter int IDLE_8BIT = 10,
   parameter int IDLE_9BIT = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic line,
   input  logic nine_bit,
   input  logic char_ok,
   input  logic idle_clr,
   output logic idle_ev
);
   localparam int MAXT = (IDLE_9BIT > IDLE_8BIT) ? IDLE_9BIT : IDLE_8BIT;
   localparam int CW   = $clog2(MAXT + 1);

   logic [CW-1:0] cnt_q, thr;
   logic          allow_q;

   initial begin
      if (IDLE_8BIT < 2 || IDLE_9BIT < 2)
         $error("rx_idle_detect: idle thresholds must be at least 2");
   end

   always_comb thr = nine_bit ? CW'(IDLE_9BIT) : CW'(IDLE_8BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         allow_q <= 1'b0;
      end else begin
         if (!enable)                cnt_q <= '0;
         else if (tick && !line)     cnt_q <= '0;
         else if (tick && cnt_q < thr) cnt_q <= cnt_q + 1'b1;

         if (!enable)       allow_q <= 1'b0;
         else if (char_ok)  allow_q <= 1'b1;
         else if (idle_clr) allow_q <= 1'b0;
      end
   end

   assign idle_ev = enable && allow_q && tick && line && (cnt_q == thr - 1'b1);

   assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && tick && !line) |=> (cnt_q == '0));
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
   import rx_status_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BUS_W     = 8,
   parameter int IDLE_8BIT = 10,
   parameter int IDLE_9BIT = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_noise,
   input  logic              sample_tick,
   input  logic              line_sample,
   input  logic              nine_bit,
   input  logic              bus_rd,
   input  logic              bus_addr,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              ie_idle,
   input  logic              dma_rx_en,
   input  logic              ie_ovr,
   input  logic              ie_noise,
   output logic              irq_idle,
   output logic              irq_ovr,
   output logic              irq_noise
);
   initial begin
      if (DATA_W > BUS_W) $error("rx_status_ctrl: DATA_W exceeds BUS_W");
      if (BUS_W <= ST_TOP) $error("rx_status_ctrl: BUS_W too narrow for status word");
   end

   logic [DATA_W-1:0]    data_q;
   logic [NUM_FLAGS-1:0] set_ev, flags, cleared;
   logic                 st_rd, dt_rd, char_in, accept, idle_ev;
   logic [BUS_W-1:0]     status_w, data_w;

   assign st_rd   = bus_rd && !bus_addr;
   assign dt_rd   = bus_rd &&  bus_addr;
   assign char_in = char_done && rx_en;
   assign accept  = char_in && !flags[FL_AVAIL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '0;
      else if (accept) data_q <= char_data;
   end

   rx_idle_detect #(.IDLE_8BIT(IDLE_8BIT), .IDLE_9BIT(IDLE_9BIT)) u_idle (
      .clk(clk), .rst_n(rst_n), .enable(rx_en), .tick(sample_tick),
      .line(line_sample), .nine_bit(nine_bit), .char_ok(accept),
      .idle_clr(cleared[FL_IDLE]), .idle_ev(idle_ev)
   );

   always_comb begin
      set_ev           = '0;
      set_ev[FL_AVAIL] = accept;
      set_ev[FL_IDLE]  = idle_ev;
      set_ev[FL_OVR]   = char_in && flags[FL_AVAIL];
      set_ev[FL_NOISE] = char_in && char_noise;
   end

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      rx_flag_cell u_cell (
         .clk(clk), .rst_n(rst_n), .set_ev(set_ev[g]), .st_rd(st_rd),
         .dt_rd(dt_rd), .flag_o(flags[g]), .cleared_o(cleared[g])
      );
   end

   always_comb begin
      status_w           = '0;
      status_w[ST_AVAIL] = flags[FL_AVAIL];
      status_w[ST_IDLE]  = flags[FL_IDLE];
      status_w[ST_OVR]   = flags[FL_OVR];
      status_w[ST_NOISE] = flags[FL_NOISE];
   end

   if (DATA_W < BUS_W) begin : g_pad
      assign data_w = {{(BUS_W-DATA_W){1'b0}}, data_q};
   end else begin : g_nopad
      assign data_w = data_q;
   end

   assign rd_data   = bus_addr ? data_w : status_w;
   assign irq_idle  = flags[FL_IDLE] && ie_idle && !dma_rx_en;
   assign irq_ovr   = flags[FL_OVR] && ie_ovr;
   assign irq_noise = flags[FL_NOISE] && ie_noise;

   assert_ovr_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (char_in && flags[FL_AVAIL]) |=> $stable(data_q));
   assert_load_sets_avail_R1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> flags[FL_AVAIL]);
   assert_idle_dma_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rx_en |-> !irq_idle);
endmodule

// File: tb/rx_status_ctrl_bench.sv
`timescale 1ns/100ps
module rx_status_ctrl_bench;
   logic clk = 0, rst_n = 0;
   logic rx_en = 0, char_done = 0, char_noise = 0, sample_tick = 0, line_sample = 1;
   logic nine_bit = 0, bus_rd = 0, bus_addr = 0;
   logic ie_idle = 0, dma_rx_en = 0, ie_ovr = 0, ie_noise = 0;
   logic [7:0] char_data = 0, rd_data;
   logic irq_idle, irq_ovr, irq_noise;
   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   rx_status_ctrl u_rx_status_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_done(char_done),
      .char_data(char_data), .char_noise(char_noise), .sample_tick(sample_tick),
      .line_sample(line_sample), .nine_bit(nine_bit), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .rd_data(rd_data), .ie_idle(ie_idle),
      .dma_rx_en(dma_rx_en), .ie_ovr(ie_ovr), .ie_noise(ie_noise),
      .irq_idle(irq_idle), .irq_ovr(irq_ovr), .irq_noise(irq_noise)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_char(input logic [7:0] d, input logic nz);
      @(negedge clk); char_done = 1; char_data = d; char_noise = nz;
      @(negedge clk); char_done = 0; char_noise = 0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] v);
      @(negedge clk); bus_rd = 1; bus_addr = a; #1 v = rd_data;
      @(negedge clk); bus_rd = 0; bus_addr = 0;
   endtask

   task automatic read_chk(input logic a, input logic [7:0] exp, input string req);
      logic [7:0] v;
      bus_read(a, v);
      check(req, v, exp);
   endtask

   task automatic ticks(input int n, input logic val);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sample_tick = 1; line_sample = val;
         @(negedge clk); sample_tick = 0; line_sample = 1;
      end
   endtask

   // op: 0 char, 1 status read (check), 2 data read (check)
   typedef struct packed { logic [1:0] op; logic [7:0] dat; logic nz; logic [7:0] exp; logic [3:0] req; } vec_t;
   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 8'h00, 1'b0, 8'h00, 4'd9}, '{2'd2, 8'h00, 1'b0, 8'h00, 4'd9},
      '{2'd0, 8'hA5, 1'b0, 8'h00, 4'd1}, '{2'd1, 8'h00, 1'b0, 8'h20, 4'd1},
      '{2'd2, 8'h00, 1'b0, 8'hA5, 4'd1}, '{2'd1, 8'h00, 1'b0, 8'h00, 4'd2},
      '{2'd0, 8'h3C, 1'b0, 8'h00, 4'd2}, '{2'd2, 8'h00, 1'b0, 8'h3C, 4'd2},
      '{2'd1, 8'h00, 1'b0, 8'h20, 4'd2}, '{2'd0, 8'h77, 1'b0, 8'h00, 4'd3},
      '{2'd2, 8'h00, 1'b0, 8'h3C, 4'd3}, '{2'd1, 8'h00, 1'b0, 8'h08, 4'd4},
      '{2'd2, 8'h00, 1'b0, 8'h3C, 4'd4}, '{2'd1, 8'h00, 1'b0, 8'h00, 4'd4},
      '{2'd0, 8'h5A, 1'b1, 8'h00, 4'd5}, '{2'd1, 8'h00, 1'b0, 8'h24, 4'd5},
      '{2'd2, 8'h00, 1'b0, 8'h5A, 4'd5}, '{2'd1, 8'h00, 1'b0, 8'h00, 4'd5}
   };

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1; rx_en = 1;
      // table: R1 R2 R3 R4 R5 R9 tags carried in req field
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         if (VECS[i].op == 2'd0) send_char(VECS[i].dat, VECS[i].nz);
         else read_chk(VECS[i].op == 2'd2, VECS[i].exp, tag);
      end

      // R7: no idle after enable until a character arrives
      @(negedge clk); rx_en = 0; @(negedge clk); rx_en = 1;
      ticks(12, 1);
      read_chk(0, 8'h00, "R7 idle before char");
      send_char(8'h11, 0);
      read_chk(0, 8'h20, "R1 char after reenable");
      read_chk(1, 8'h11, "R1 data after reenable");
      // R6: 8-bit threshold 10, restart on 0
      ticks(1, 0); ticks(9, 1);
      read_chk(0, 8'h00, "R6 nine ones");
      ticks(1, 0); ticks(9, 1);
      read_chk(0, 8'h00, "R6 restart on zero");
      ticks(1, 1);
      read_chk(0, 8'h10, "R6 ten ones");
      read_chk(1, 8'h11, "R6 data read");
      read_chk(0, 8'h00, "R6 idle cleared");
      ticks(1, 0); ticks(10, 1);
      read_chk(0, 8'h00, "R7 no idle after clear");
      // R6: 9-bit threshold 11
      nine_bit = 1;
      send_char(8'h22, 0);
      read_chk(0, 8'h20, "R1 char 9bit");
      read_chk(1, 8'h22, "R1 data 9bit");
      ticks(1, 0); ticks(10, 1);
      read_chk(0, 8'h00, "R6 ten ones 9bit");
      ticks(1, 1);
      read_chk(0, 8'h10, "R6 eleven ones 9bit");

      // R8 interrupt gating
      @(negedge clk); ie_idle = 1; dma_rx_en = 0; #1 check("R8 idle irq", irq_idle, 1);
      @(negedge clk); dma_rx_en = 1; #1 check("R8 idle masked by dma", irq_idle, 0);
      send_char(8'h33, 0); send_char(8'h44, 0); send_char(8'h55, 1);
      @(negedge clk); ie_ovr = 0; #1 check("R8 ovr irq disabled", irq_ovr, 0);
      @(negedge clk); ie_ovr = 1; #1 check("R8 ovr irq", irq_ovr, 1);
      @(negedge clk); ie_noise = 0; #1 check("R8 noise irq disabled", irq_noise, 0);
      @(negedge clk); ie_noise = 1; #1 check("R8 noise irq", irq_noise, 1);
      read_chk(0, 8'h3C, "R3 all flags");
      // R10: data read coincides with a noisy overrun character
      @(negedge clk); bus_rd = 1; bus_addr = 1; char_done = 1; char_data = 8'hEE; char_noise = 1;
      #1 check("R3 data held at collision", rd_data, 8'h33);
      @(negedge clk); bus_rd = 0; bus_addr = 0; char_done = 0; char_noise = 0;
      read_chk(0, 8'h0C, "R10 set wins");

      // R9 reset
      @(negedge clk); rst_n = 0;
      @(negedge clk); #1 check("R9 irq after reset", {5'd0, irq_idle, irq_ovr, irq_noise}, 8'h00);
      rst_n = 1;
      read_chk(0, 8'h00, "R9 status after reset");
      read_chk(1, 8'h00, "R9 data after reset");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule